// File: doc/BRIEF.md
# Self-Starting Five-Step Code Counter

This block is a 3-bit synchronous counter. It does not count in binary order. It steps through the repeating cycle 2, 3, 5, 1, 7 and then returns to 2, so its modulus is 5. All three state bits are flip-flop stages with J-K behaviour, and they share one clock. The J and K drive of each stage comes only from combinational logic on the present state. The count value is the binary number formed by the three bits, with bit 2 as the most significant bit.

Three codes are never part of the cycle: 0, 4 and 6. An elaboration-time parameter, `ROUTE_TO_TWO`, chooses how the counter leaves them:

- With the parameter at 1, each unused code goes straight to 2.
- With the parameter at 0, each unused code goes to the next binary value, which is always in the cycle.

Either way, the counter joins the cycle on the first clock edge, so it needs no start-up help. A synchronous reset places the counter at 2. A test-only load input puts any code into the stages so that unused codes can be reached.

Top module: `seqcnt_selfstart`

## Requirements
- R1: With `rst` high at a rising edge, `count` becomes 2 after that edge. This holds whatever `tst_load` and `tst_code` are.
- R2: With `rst` and `tst_load` low, each rising edge moves `count` along the cycle 2→3, 3→5, 5→1, 1→7 and 7→2.
- R3: With `ROUTE_TO_TWO`=1, and with `rst` and `tst_load` low, codes 0, 4 and 6 each move to 2 on the next rising edge.
- R4: With `ROUTE_TO_TWO`=0, and with `rst` and `tst_load` low, code 0 moves to 1, code 4 moves to 5 and code 6 moves to 7 on the next rising edge.
- R5: Starting from 2, `count` takes the value 2 again after exactly five rising edges and not earlier.
- R6: From any of the eight codes, one free-running edge later `count` is one of {1, 2, 3, 5, 7}.
- R7: With `rst` low and `tst_load` high at a rising edge, `count` becomes `tst_code` after that edge.
- R8: Each state bit acts as a J-K stage on the rising edge, with the J and K inputs depending only on the present count:
  - J=0, K=0 keeps the bit.
  - J=0, K=1 clears the bit.
  - J=1, K=0 sets the bit.
  - J=1, K=1 inverts the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all three stages, rising edge |
| rst | input | 1 | Synchronous active-high reset to code 2 |
| tst_load | input | 1 | Test-only synchronous load enable |
| tst_code | input | 3 | Code written by `tst_load` |
| count | output | 3 | Present count, bit 2 most significant |

## Verification
The unused codes 0, 4 and 6 are the hard case. A correct counter never enters them after reset, so the routing logic cannot be reached by clocking alone. The stimulus uses the test load to put each of the eight codes into the stages one at a time. It then drops the load for one edge and compares the free-running successor against an independently written table. Two instances, one per routing mode, run side by side so that both variants are checked against the same stimulus.

// File: rtl/seqcnt_pkg.sv
package seqcnt_pkg;

   localparam int unsigned CODE_W = 3;
   localparam int unsigned NCODES = 1 << CODE_W;

   typedef logic [CODE_W-1:0] code_t;

   localparam code_t START_CODE = code_t'(2);

   // successor inside the five-step cycle; unused codes return themselves
   function automatic code_t cycle_next(input code_t c);
      case (c)
         code_t'(2): cycle_next = code_t'(3);
         code_t'(3): cycle_next = code_t'(5);
         code_t'(5): cycle_next = code_t'(1);
         code_t'(1): cycle_next = code_t'(7);
         code_t'(7): cycle_next = code_t'(2);
         default:    cycle_next = c;
      endcase
   endfunction

   function automatic logic is_cycle_code(input code_t c);
      is_cycle_code = (c == code_t'(1)) || (c == code_t'(2)) ||
                      (c == code_t'(3)) || (c == code_t'(5)) ||
                      (c == code_t'(7));
   endfunction

endpackage

// File: rtl/seqcnt_jk_stage.sv
module seqcnt_jk_stage #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic ld,
   input  logic ld_val,
   input  logic j,
   input  logic k,
   output logic q
);

   logic q_r;

   always_ff @(posedge clk) begin
      if (rst) begin
         q_r <= RST_VAL;
      end else if (ld) begin
         q_r <= ld_val;
      end else begin
         unique case ({j, k})
            2'b00: q_r <= q_r;
            2'b01: q_r <= 1'b0;
            2'b10: q_r <= 1'b1;
            2'b11: q_r <= ~q_r;
         endcase
      end
   end

   assign q = q_r;

   p_jk_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!ld && !j && !k) |=> (q == $past(q)));
   p_jk_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (!ld && !j && k) |=> (q == 1'b0));
   p_jk_set_r8: assert property (@(posedge clk) disable iff (rst)
      (!ld && j && !k) |=> (q == 1'b1));
   p_jk_toggle_r8: assert property (@(posedge clk) disable iff (rst)
      (!ld && j && k) |=> (q != $past(q)));

endmodule

// File: rtl/seqcnt_drive.sv
module seqcnt_drive
   import seqcnt_pkg::*;
#(
   parameter int ROUTE_TO_TWO = 1,
   parameter int USE_TOGGLE   = 0
) (
   input  code_t state,
   output code_t j,
   output code_t k
);

   code_t nxt;

   generate
      if (ROUTE_TO_TWO != 0) begin : g_route_start
         always_comb begin
            if (is_cycle_code(state)) nxt = cycle_next(state);
            else                      nxt = START_CODE;
         end
      end else begin : g_route_binary
         always_comb begin
            if (is_cycle_code(state)) nxt = cycle_next(state);
            else                      nxt = state + code_t'(1);
         end
      end
   endgenerate

   generate
      for (genvar b = 0; b < CODE_W; b++) begin : g_exc
         if (USE_TOGGLE != 0) begin : g_tog
            assign j[b] = state[b] ^ nxt[b];
            assign k[b] = state[b] ^ nxt[b];
         end else begin : g_setclr
            assign j[b] = ~state[b] & nxt[b];
            assign k[b] = state[b] & ~nxt[b];
         end
      end
   endgenerate

endmodule

// File: rtl/seqcnt_selfstart.sv
module seqcnt_selfstart
   import seqcnt_pkg::*;
#(
   parameter int CNT_W        = 3,
   parameter int ROUTE_TO_TWO = 1,
   parameter int USE_TOGGLE   = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tst_load,
   input  logic [CNT_W-1:0] tst_code,
   output logic [CNT_W-1:0] count
);

   generate
      if (CNT_W != CODE_W) begin : g_bad_width
         $error("seqcnt_selfstart: CNT_W must equal 3");
      end
      if (ROUTE_TO_TWO != 0 && ROUTE_TO_TWO != 1) begin : g_bad_route
         $error("seqcnt_selfstart: ROUTE_TO_TWO must be 0 or 1");
      end
      if (USE_TOGGLE != 0 && USE_TOGGLE != 1) begin : g_bad_exc
         $error("seqcnt_selfstart: USE_TOGGLE must be 0 or 1");
      end
   endgenerate

   code_t state;
   code_t j_vec;
   code_t k_vec;

   seqcnt_drive #(
      .ROUTE_TO_TWO(ROUTE_TO_TWO),
      .USE_TOGGLE  (USE_TOGGLE)
   ) u_drive (
      .state(state),
      .j    (j_vec),
      .k    (k_vec)
   );

   generate
      for (genvar b = 0; b < CODE_W; b++) begin : g_bit
         seqcnt_jk_stage #(
            .RST_VAL(START_CODE[b])
         ) u_stg (
            .clk   (clk),
            .rst   (rst),
            .ld    (tst_load),
            .ld_val(tst_code[b]),
            .j     (j_vec[b]),
            .k     (k_vec[b]),
            .q     (state[b])
         );
      end
   endgenerate

   assign count = state;

   p_reset_start_r1: assert property (@(posedge clk)
      rst |=> (count == 3'd2));
   p_load_r7: assert property (@(posedge clk) disable iff (rst)
      tst_load |=> (count == $past(tst_code)));
   p_step_2_r2: assert property (@(posedge clk) disable iff (rst)
      (!tst_load && count == 3'd2) |=> (count == 3'd3));
   p_step_3_r2: assert property (@(posedge clk) disable iff (rst)
      (!tst_load && count == 3'd3) |=> (count == 3'd5));
   p_step_5_r2: assert property (@(posedge clk) disable iff (rst)
      (!tst_load && count == 3'd5) |=> (count == 3'd1));
   p_step_1_r2: assert property (@(posedge clk) disable iff (rst)
      (!tst_load && count == 3'd1) |=> (count == 3'd7));
   p_step_7_r2: assert property (@(posedge clk) disable iff (rst)
      (!tst_load && count == 3'd7) |=> (count == 3'd2));
   p_self_start_r6: assert property (@(posedge clk) disable iff (rst)
      !tst_load |=> is_cycle_code(count));

   generate
      if (ROUTE_TO_TWO != 0) begin : g_chk_start
         p_unused_start_r3: assert property (@(posedge clk)
            disable iff (rst)
            (!tst_load && (count == 3'd0 || count == 3'd4 ||
                           count == 3'd6)) |=> (count == 3'd2));
      end else begin : g_chk_binary
         p_unused_binary_r4: assert property (@(posedge clk)
            disable iff (rst)
            (!tst_load && (count == 3'd0 || count == 3'd4 ||
                           count == 3'd6)) |=> (count == $past(count) + 3'd1));
      end
   endgenerate

endmodule

// File: tb/sim_seqcnt_selfstart.sv
module sim_seqcnt_selfstart;

   localparam int CLK_P = 10;

   typedef struct {
      logic [2:0] e0;
      logic [2:0] e1;
      string      tag;
   } sb_item_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tst_load = 1'b0;
   logic [2:0] tst_code = 3'd0;
   logic [2:0] count0;
   logic [2:0] count1;

   int n_cmp = 0;
   int n_bad = 0;
   bit drv_done = 1'b0;
   sb_item_t sbq[$];

   always #(CLK_P/2) clk = ~clk;

   seqcnt_selfstart #(.ROUTE_TO_TWO(1)) u0 (
      .clk(clk), .rst(rst), .tst_load(tst_load), .tst_code(tst_code),
      .count(count0));

   seqcnt_selfstart #(.ROUTE_TO_TWO(0)) u1 (
      .clk(clk), .rst(rst), .tst_load(tst_load), .tst_code(tst_code),
      .count(count1));

   // expected successor tables, written from R2/R3/R4
   function automatic logic [2:0] exp_next(input logic [2:0] c,
                                           input bit to_two);
      case (c)
         3'd2: return 3'd3;
         3'd3: return 3'd5;
         3'd5: return 3'd1;
         3'd1: return 3'd7;
         3'd7: return 3'd2;
         3'd0: return to_two ? 3'd2 : 3'd1;
         3'd4: return to_two ? 3'd2 : 3'd5;
         default: return to_two ? 3'd2 : 3'd7;
      endcase
   endfunction

   task automatic push(input logic [2:0] e0, input logic [2:0] e1,
                       input string tag);
      sb_item_t it;
      it.e0 = e0;
      it.e1 = e1;
      it.tag = tag;
      sbq.push_back(it);
   endtask

   // monitor: one comparison per edge that has a pending item
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            n_cmp++;
            if (count0 !== it.e0) begin
               n_bad++;
               $display("FAIL %s u0: count=%0d expected=%0d",
                        it.tag, count0, it.e0);
            end
            n_cmp++;
            if (count1 !== it.e1) begin
               n_bad++;
               $display("FAIL %s u1: count=%0d expected=%0d",
                        it.tag, count1, it.e1);
            end
         end
      end
   end

   // driver
   initial begin
      logic [2:0] c;
      @(negedge clk);
      push(3'd2, 3'd2, "R1 reset");
      @(negedge clk);
      tst_load = 1'b1;
      tst_code = 3'd5;
      push(3'd2, 3'd2, "R1 reset over load");
      @(negedge clk);
      rst = 1'b0;
      tst_load = 1'b0;
      // R2 and R5: five steps from 2 return to 2, passing no 2 on the way
      c = 3'd2;
      for (int s = 1; s <= 5; s++) begin
         c = exp_next(c, 1'b1);
         push(c, c, (s == 5) ? "R5 modulus" : "R2 R8 cycle");
         @(negedge clk);
      end
      // every code: load it (R7), then one free edge (R2/R3/R4/R6)
      for (int v = 0; v < 8; v++) begin
         tst_load = 1'b1;
         tst_code = 3'(v);
         push(3'(v), 3'(v), "R7 load");
         @(negedge clk);
         tst_load = 1'b0;
         if (v == 0 || v == 4 || v == 6)
            push(exp_next(3'(v), 1'b1), exp_next(3'(v), 1'b0),
                 "R3 R4 R6 R8 unused");
         else
            push(exp_next(3'(v), 1'b1), exp_next(3'(v), 1'b0),
                 "R2 R6 R8 cycle");
         @(negedge clk);
      end
      // a longer free run after an unused start in both modes
      tst_load = 1'b1;
      tst_code = 3'd6;
      push(3'd6, 3'd6, "R7 load");
      @(negedge clk);
      tst_load = 1'b0;
      c = 3'd6;
      begin
         logic [2:0] d;
         d = 3'd6;
         for (int s = 0; s < 7; s++) begin
            c = exp_next(c, 1'b1);
            d = exp_next(d, 1'b0);
            push(c, d, "R6 R2 run");
            @(negedge clk);
         end
      end
      // reset in mid-cycle
      rst = 1'b1;
      push(3'd2, 3'd2, "R1 mid reset");
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      @(negedge clk);
      drv_done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (drv_done);
         end
         begin
            #(CLK_P * 5000);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run=hung expected=done");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               n_cmp, n_bad);
      $finish;
   end

endmodule